// File: doc/BRIEF.md
# Parity-Protected Vectored Interrupt Manager

This block takes a vector of interrupt request lines and sorts each one, through a software routing mask, into a normal-interrupt (IRQ) class or a fast-interrupt (FIQ) class. Within each class it picks the pending, enabled line with the lowest channel number. It then fetches that channel's handler address from an internal table, where every word carries one even-parity bit. The chosen addresses appear in two vector registers. The IRQ address is also driven on a direct hardware-vector output. Index registers report the winning entry number so that one shared handler can dispatch by number.

Each table lookup is parity-checked as it happens. If a looked-up word is corrupt, the block outputs a software-loaded fallback address in its place. It also sets a sticky error flag and emits a one-cycle pulse for an external error collector. A test-mode bit lets software store a word with a deliberately wrong parity bit, so that this recovery path can be exercised.

Top module: `vimp_top`

## Requirements
- R1: After reset, every register reads 0, the table holds zero words with correct parity, `irq_o`, `fiq_o` and `par_err_pulse_o` are 0, and `hw_vec_o` is 0.
- R2: A channel takes part only when its enable bit (address 0) is 1. Routing bit 1 (address 1) puts it in the FIQ class and 0 puts it in the IRQ class. `irq_o` and `fiq_o` are high while their class has a participating request.
- R3: In each class the lowest pending channel c wins. The index register (address 4 for IRQ, 5 for FIQ) reads c+1. When the class is idle, the index reads 0 and the lookup uses table entry 0.
- R4: The vector registers (address 6 for IRQ, 7 for FIQ) read the table word at the class's index. Table entry e sits at address 16+e, with e from 0 to the channel count.
- R5: `hw_vec_o` always equals the IRQ vector register value, and bit 0 passes through unchanged.
- R6: A table write stores the even parity of the data. While the test bit (status bit 1) is set, it stores the inverted parity instead. The stored data reads back unchanged either way.
- R7: When a looked-up word fails parity, that class's vector register shows the fallback register (address 2) instead. For the IRQ class this also applies to `hw_vec_o`.
- R8: Any lookup parity error sets the flag (status address 3, bit 0) at the next edge. Writing 1 to bit 0 clears it. If an error and a clear fall in the same cycle, the set wins.
- R9: `par_err_pulse_o` is high for exactly the one cycle that follows the first cycle of a parity error episode.
- R10: The enable, routing and fallback registers read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Interrupt request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW | Register address for read and write |
| reg_wdata_i | input | VW | Write data |
| reg_rdata_o | output | VW | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | IRQ class has a pending request |
| fiq_o | output | 1 | FIQ class has a pending request |
| hw_vec_o | output | VW | Direct hardware vector for the IRQ winner |
| par_err_pulse_o | output | 1 | One-cycle parity error pulse |

## Verification
A software clear of the parity flag can land in the same cycle as a fresh lookup error. To provoke this, a request on a channel whose entry was written in test mode is held active, and the clear is written while that request stays up. The flag must still read 1 afterwards. A clear issued after the request drops must then read 0. Random traffic also lets table rewrites and corrupted lookups coincide, and each cycle is judged against a bench model of the flag and the pulse.

// File: rtl/vimp_pkg.sv
`timescale 1ns/1ps
package vimp_pkg;
  localparam int unsigned VEC_W  = 32;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] A_EN     = 6'd0;
  localparam logic [REG_AW-1:0] A_ROUTE  = 6'd1;
  localparam logic [REG_AW-1:0] A_FALLBK = 6'd2;
  localparam logic [REG_AW-1:0] A_STAT   = 6'd3;
  localparam logic [REG_AW-1:0] A_IRQIDX = 6'd4;
  localparam logic [REG_AW-1:0] A_FIQIDX = 6'd5;
  localparam logic [REG_AW-1:0] A_IRQVEC = 6'd6;
  localparam logic [REG_AW-1:0] A_FIQVEC = 6'd7;
  localparam logic [REG_AW-1:0] A_TBL    = 6'd16;

  localparam int unsigned ST_FLAG = 0;
  localparam int unsigned ST_TEST = 1;
endpackage

// File: rtl/vimp_prio.sv
`timescale 1ns/1ps
module vimp_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i + 1);
    end
  end

  // R3: the winner is pending and nothing below it is pending
  assert_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (req[idx - IW'(1)] && ((req & ((N'(1) << (idx - IW'(1))) - N'(1))) == '0)));

  // R3: an idle class reports index 0
  assert_idle_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (idx == '0));
endmodule

// File: rtl/vimp_vtab.sv
`timescale 1ns/1ps
module vimp_vtab #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          flip,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  input  logic [IW-1:0] rc,
  output logic [DW-1:0] da,
  output logic          ea,
  output logic [DW-1:0] db,
  output logic          eb,
  output logic [DW-1:0] dc
);
  localparam int unsigned DEPTH = 1 << IW;

  logic [DW:0] mem_q [DEPTH];
  logic [DW:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (we) mem_d[waddr] = {(^wdata) ^ flip, wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  // parity check on every lookup: odd total weight means corruption
  always_comb begin
    da = mem_q[ra][DW-1:0];
    ea = ^mem_q[ra];
    db = mem_q[rb][DW-1:0];
    eb = ^mem_q[rb];
    dc = mem_q[rc][DW-1:0];
  end

  // R6: normal write leaves an even-weight word, test write an odd one
  assert_even_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !flip) |=> ((^mem_q[$past(waddr)]) == 1'b0));
  assert_odd_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && flip) |=> ((^mem_q[$past(waddr)]) == 1'b1));
endmodule

// File: rtl/vimp_top.sv
`timescale 1ns/1ps
module vimp_top #(
  parameter int unsigned NCH = 8,
  parameter int unsigned VW  = vimp_pkg::VEC_W,
  parameter int unsigned RAW = vimp_pkg::REG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [VW-1:0]  reg_wdata_i,
  output logic [VW-1:0]  reg_rdata_o,
  output logic           irq_o,
  output logic           fiq_o,
  output logic [VW-1:0]  hw_vec_o,
  output logic           par_err_pulse_o
);
  import vimp_pkg::*;

  localparam int unsigned NENT = NCH + 1;
  localparam int unsigned IW   = $clog2(NENT);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic [NCH-1:0] en_q, en_d, route_q, route_d;
  logic [VW-1:0]  fb_q, fb_d;
  logic           flag_q, flag_d, test_q, test_d;
  logic           pulse_q, pulse_d, errd_q, errd_d;

  // write decode
  logic           wr_en, wr_route, wr_fb, wr_stat, tbl_hit, tbl_we;
  logic [RAW-1:0] tbl_off;
  logic [IW-1:0]  tbl_idx;

  always_comb begin
    wr_en    = reg_we_i && (reg_addr_i == RAW'(A_EN));
    wr_route = reg_we_i && (reg_addr_i == RAW'(A_ROUTE));
    wr_fb    = reg_we_i && (reg_addr_i == RAW'(A_FALLBK));
    wr_stat  = reg_we_i && (reg_addr_i == RAW'(A_STAT));
    tbl_off  = reg_addr_i - RAW'(A_TBL);
    tbl_hit  = (reg_addr_i >= RAW'(A_TBL)) && (tbl_off < RAW'(NENT));
    tbl_we   = reg_we_i && tbl_hit;
    tbl_idx  = IW'(tbl_off);
  end

  // class separation and priority
  logic [NCH-1:0] irq_req, fiq_req;
  logic           irq_v, fiq_v;
  logic [IW-1:0]  irq_idx, fiq_idx;

  assign irq_req = req_i & en_q & ~route_q;
  assign fiq_req = req_i & en_q & route_q;

  vimp_prio #(.N(NCH), .IW(IW)) u_pirq (
    .clk(clk), .rst_n(rst_q_n), .req(irq_req), .valid(irq_v), .idx(irq_idx));
  vimp_prio #(.N(NCH), .IW(IW)) u_pfiq (
    .clk(clk), .rst_n(rst_q_n), .req(fiq_req), .valid(fiq_v), .idx(fiq_idx));

  // vector table lookups
  logic [VW-1:0] irq_word, fiq_word, rd_word;
  logic          irq_err, fiq_err, err_now;
  logic [VW-1:0] irq_vec, fiq_vec;

  vimp_vtab #(.DW(VW), .IW(IW)) u_tab (
    .clk(clk), .rst_n(rst_q_n),
    .we(tbl_we), .flip(test_q), .waddr(tbl_idx), .wdata(reg_wdata_i),
    .ra(irq_idx), .rb(fiq_idx), .rc(tbl_idx),
    .da(irq_word), .ea(irq_err), .db(fiq_word), .eb(fiq_err), .dc(rd_word));

  always_comb begin
    irq_vec = irq_err ? fb_q : irq_word;
    fiq_vec = fiq_err ? fb_q : fiq_word;
    err_now = irq_err | fiq_err;
  end

  // next state
  always_comb begin
    en_d    = wr_en    ? reg_wdata_i[NCH-1:0] : en_q;
    route_d = wr_route ? reg_wdata_i[NCH-1:0] : route_q;
    fb_d    = wr_fb    ? reg_wdata_i          : fb_q;
    test_d  = wr_stat  ? reg_wdata_i[ST_TEST] : test_q;
    flag_d  = (flag_q & ~(wr_stat & reg_wdata_i[ST_FLAG])) | err_now;
    pulse_d = err_now & ~errd_q;
    errd_d  = err_now;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      en_q    <= '0;
      route_q <= '0;
      fb_q    <= '0;
      test_q  <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      errd_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      route_q <= route_d;
      fb_q    <= fb_d;
      test_q  <= test_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
      errd_q  <= errd_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if      (reg_addr_i == RAW'(A_EN))     reg_rdata_o = VW'(en_q);
    else if (reg_addr_i == RAW'(A_ROUTE))  reg_rdata_o = VW'(route_q);
    else if (reg_addr_i == RAW'(A_FALLBK)) reg_rdata_o = fb_q;
    else if (reg_addr_i == RAW'(A_STAT))   reg_rdata_o = VW'({test_q, flag_q});
    else if (reg_addr_i == RAW'(A_IRQIDX)) reg_rdata_o = VW'(irq_idx);
    else if (reg_addr_i == RAW'(A_FIQIDX)) reg_rdata_o = VW'(fiq_idx);
    else if (reg_addr_i == RAW'(A_IRQVEC)) reg_rdata_o = irq_vec;
    else if (reg_addr_i == RAW'(A_FIQVEC)) reg_rdata_o = fiq_vec;
    else if (tbl_hit)                      reg_rdata_o = rd_word;
  end

  assign irq_o           = irq_v;
  assign fiq_o           = fiq_v;
  assign hw_vec_o        = irq_vec;
  assign par_err_pulse_o = pulse_q;

  // R8: an error always leaves the flag set at the next edge
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_now |=> flag_q);
  // R8: without a clear write, a set flag stays set
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_q && !(wr_stat && reg_wdata_i[ST_FLAG])) |=> flag_q);
  // R9: the pulse never lasts two cycles
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    par_err_pulse_o |=> !par_err_pulse_o);
  // R9: a pulse is always accompanied by a set flag
  assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    par_err_pulse_o |-> flag_q);
endmodule

// File: tb/sim_vimp_top.sv
`timescale 1ns/1ps
module sim_vimp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o, pulse;
  logic [31:0] hw_vec;

  always #2 clk = ~clk;

  vimp_top u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .hw_vec_o(hw_vec), .par_err_pulse_o(pulse));

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic [31:0] m_tbl [0:8];
  logic        m_bad [0:8];
  logic [7:0]  m_en, m_route;
  logic [31:0] m_fb;
  logic        m_flag, m_test, m_pulse, m_errd;

  function automatic int win(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i + 1;
    return 0;
  endfunction
  function automatic logic [7:0] irqm();
    return req & m_en & ~m_route;
  endfunction
  function automatic logic [7:0] fiqm();
    return req & m_en & m_route;
  endfunction
  function automatic logic [31:0] vec_of(input int e);
    return m_bad[e] ? m_fb : m_tbl[e];
  endfunction
  function automatic logic [31:0] exp_reg(input logic [5:0] a);
    case (a)
      6'd0: return {24'd0, m_en};
      6'd1: return {24'd0, m_route};
      6'd2: return m_fb;
      6'd3: return {30'd0, m_test, m_flag};
      6'd4: return 32'(win(irqm()));
      6'd5: return 32'(win(fiqm()));
      6'd6: return vec_of(win(irqm()));
      6'd7: return vec_of(win(fiqm()));
      default: return (a >= 6'd16 && a <= 6'd24) ? m_tbl[a - 6'd16] : 32'd0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one clock cycle with optional write; model updated at the edge
  task automatic cyc(input logic we, input logic [5:0] a, input logic [31:0] d);
    logic e;
    reg_we = we; reg_addr = a; reg_wdata = d;
    e = m_bad[win(irqm())] | m_bad[win(fiqm())];
    @(posedge clk);
    m_pulse = e & ~m_errd;
    m_errd  = e;
    m_flag  = (m_flag & ~(we && a == 6'd3 && d[0])) | e;
    if (we) begin
      if (a == 6'd0) m_en = d[7:0];
      else if (a == 6'd1) m_route = d[7:0];
      else if (a == 6'd2) m_fb = d;
      else if (a == 6'd3) m_test = d[1];
      else if (a >= 6'd16 && a <= 6'd24) begin
        m_tbl[a - 6'd16] = d;
        m_bad[a - 6'd16] = m_test;
      end
    end
    @(negedge clk);
    reg_we = 1'b0;
    chk({31'd0, pulse}, {31'd0, m_pulse}, "R9 pulse");
    chk(hw_vec, vec_of(win(irqm())), "R5 R7 hw_vec");
    chk({31'd0, irq_o}, {31'd0, |irqm()}, "R2 irq_o");
    chk({31'd0, fiq_o}, {31'd0, |fiqm()}, "R2 fiq_o");
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    cyc(1'b0, a, 32'd0);
    chk(reg_rdata, exp_reg(a), tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) begin m_tbl[i] = '0; m_bad[i] = 1'b0; end
    m_en = '0; m_route = '0; m_fb = '0;
    m_flag = 1'b0; m_test = 1'b0; m_pulse = 1'b0; m_errd = 1'b0;
    rst_n = 1'b0; req = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    chk(hw_vec, 32'd0, "R1 hw_vec in reset");
    chk({31'd0, pulse}, 32'd0, "R1 pulse in reset");
    rst_n = 1'b1;
    cyc(1'b0, 6'd0, 32'd0);
    cyc(1'b0, 6'd0, 32'd0);
    for (int a = 0; a < 8; a++) rd(6'(a), "R1 reset register");
    rd(6'd20, "R1 reset table");

    // configuration, R10 readback
    cyc(1'b1, 6'd0, 32'hFF);
    cyc(1'b1, 6'd1, 32'hF0);
    cyc(1'b1, 6'd2, 32'hDEAD_0000);
    rd(6'd0, "R10 enable"); rd(6'd1, "R10 route"); rd(6'd2, "R10 fallback");
    rd(6'd9, "R10 unmapped"); rd(6'd40, "R10 unmapped");
    for (int e = 0; e < 9; e++)
      cyc(1'b1, 6'(16 + e), 32'h1000_0000 + 32'(e * 16) + ((e == 4) ? 32'd1 : 32'd0));
    rd(6'd20, "R6 table readback");

    // priority and vectors
    req = 8'h06; rd(6'd4, "R3 irq tie"); rd(6'd6, "R4 irq vector");
    req = 8'h30; rd(6'd5, "R3 fiq tie"); rd(6'd7, "R4 fiq vector");
    req = 8'h00; rd(6'd4, "R3 idle index"); rd(6'd6, "R3 phantom vector");
    req = 8'h08; cyc(1'b0, 6'd0, 32'd0);
    chk({31'd0, hw_vec[0]}, 32'd1, "R5 bit0 passthrough");
    cyc(1'b1, 6'd0, 32'hFD);
    req = 8'h02; rd(6'd4, "R2 disabled ignored");
    cyc(1'b1, 6'd0, 32'hFF);

    // parity injection on IRQ entry of channel 1
    cyc(1'b1, 6'd3, 32'd2);
    cyc(1'b1, 6'd18, 32'h1000_0020);
    cyc(1'b1, 6'd3, 32'd0);
    req = 8'h00; rd(6'd18, "R6 corrupted readback");
    req = 8'h02; cyc(1'b0, 6'd0, 32'd0);
    rd(6'd6, "R7 irq fallback");
    rd(6'd3, "R8 flag set");
    cyc(1'b1, 6'd3, 32'd1);
    rd(6'd3, "R8 set wins over clear");
    req = 8'h00; cyc(1'b1, 6'd3, 32'd1);
    rd(6'd3, "R8 cleared");
    // FIQ entry of channel 5
    cyc(1'b1, 6'd3, 32'd2);
    cyc(1'b1, 6'd22, 32'h1000_0060);
    cyc(1'b1, 6'd3, 32'd0);
    req = 8'h20; rd(6'd7, "R7 fiq fallback");
    rd(6'd3, "R8 flag from fiq");
    req = 8'h00; cyc(1'b1, 6'd22, 32'h1000_0060);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 10) begin
        req = 8'($urandom);
        rd(6'(4 + ($urandom % 4)), "R3 R4 R7 random lookup");
      end else if (r < 13) begin
        cyc(1'b1, 6'(16 + ($urandom % 9)), $urandom);
      end else if (r == 13) begin
        cyc(1'b1, 6'd3, 32'($urandom % 4));
      end else if (r < 16) begin
        cyc(1'b1, 6'($urandom % 2), 32'($urandom));
      end else if (r == 16) begin
        cyc(1'b1, 6'd2, $urandom);
      end else begin
        rd(6'(($urandom % 2 == 0) ? ($urandom % 8) : (16 + ($urandom % 9))),
           "R6 R8 R10 random read");
      end
    end
    rd(6'd3, "R8 final flag");

    summary();
    $finish;
  end
endmodule